// File: doc/BRIEF.md
# SDRAM Address and Mask Generator

This block turns a flat word address from a requester into the multiplexed fields that an SDR SDRAM expects. A command sequencer tells it which phase it is in: row activate, column read/write, or all-banks precharge/refresh. The block then registers the matching value onto the SDRAM address bus, the bank-select lines, a dedicated A10 command line and the two byte-lane data-mask outputs. Because the outputs are registered, they appear on the same clock edge as the command the sequencer issues for that phase.

The split of the address into column, row and bank fields is set at run time by two configuration inputs: the page size (256, 512 or 1024 words) and the data bus width (32 or 64 bits). In 64-bit mode the lowest address bit picks the 32-bit half of a 64-bit word. The whole bus moves up by one position, and that bit steers the data masks on narrow writes. Device address bit 10 never travels on the shared address bus. It goes out on the A10 pin, and its slot on the bus is driven low.

Top module: `sdram_addr_mask_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `sdAddr`, `sdBank`, `sdA10`, `hdqm` and `ldqm` are all 0 until the first load phase.
- R2: The column field is taken from the lowest address bits. It is `c` bits wide, where `c` is 8, 9 or 10 for `pageCode` 2'b00, 2'b01 or 2'b10. In 32-bit mode (`bus64`=0) it is `reqAddr[c-1:0]`; in 64-bit mode (`bus64`=1) it is `reqAddr[c:1]`.
- R3: The row field sits directly above the column field. It is 14 bits wide in 32-bit mode and 13 bits wide in 64-bit mode. The 2-bit bank field sits directly above the row field.
- R4: Device address bit k is driven on `sdAddr[k]` in 32-bit mode and on `sdAddr[k+1]` in 64-bit mode. Device bit 10 appears only on `sdA10`, and its bus slot (`sdAddr[10]` in 32-bit mode, `sdAddr[11]` in 64-bit mode) is 0. In 64-bit mode `sdAddr[0]` is 0.
- R5: In the column phase (`phase`=2'b10), the bus carries only the column field, with all higher device bits 0. `sdA10` is 0 and `sdBank` is the bank field.
- R6: In the all-banks phase (`phase`=2'b11), `sdA10` is 1, and `sdAddr`, `sdBank`, `hdqm` and `ldqm` are 0.
- R7: In the hold phase (`phase`=2'b00), all outputs keep their values whatever the other inputs do.
- R8: In 64-bit mode, a column-phase write with `acc64`=0 gives `hdqm`=1, `ldqm`=0 when `reqAddr[0]`=0, and `hdqm`=0, `ldqm`=1 when `reqAddr[0]`=1. A write with `acc64`=1 gives both 0.
- R9: Both masks are 0 after a column-phase read in any mode, after any column-phase write in 32-bit mode, and after a row phase (`phase`=2'b01).
- R10: Outputs change only at the rising clock edge that samples the phase, so the result of a phase is visible one clock after it is presented.
- R11: `pageCode` 2'b11 is reserved and decodes exactly like 2'b10 (1024-word page).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phase | input | 2 | 00 hold, 01 row activate, 10 column read/write, 11 all-banks |
| reqAddr | input | ADDR_W | Flat word address of the request |
| isWrite | input | 1 | 1 for a write access, 0 for a read |
| acc64 | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| bus64 | input | 1 | Configured bus width: 1 = 64-bit, 0 = 32-bit |
| pageCode | input | 2 | Page size: 00 = 256, 01 = 512, 10/11 = 1024 words |
| sdAddr | output | BUS_W | Multiplexed SDRAM address bus |
| sdBank | output | BANK_W | Bank-select lines |
| sdA10 | output | 1 | Dedicated A10 / all-banks command line |
| hdqm | output | 1 | Upper-lane write mask |
| ldqm | output | 1 | Lower-lane write mask |

## Verification
Addresses are built from chosen bank, row and column values under every page code and both bus widths, so that a field cut at the wrong bit shows up as a wrong bank or a stray bus bit. Row values with device bit 10 set are paired with values that have bits 11 to 13 set. These pairs separate a correct move of bit 10 onto the A10 pin from a plain shift of the whole bus. Narrow writes to even and odd addresses, wide writes, reads, and writes in 32-bit mode are each tried in turn. Together they show which of the two mask lanes is tied to address parity, and that the masks are cleared in each case where they should be. Hold cycles carrying changed inputs, and a check taken just before the clock edge, show that the outputs are registered and only load in a load phase.

// File: rtl/sdram_map_pkg.sv
package sdram_map_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_ROW  = 2'd1,
    PH_COL  = 2'd2,
    PH_ALL  = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadRow;
    logic loadCol;
    logic loadAll;
    logic maskHi;
    logic maskLo;
    logic wide;
  } strobe_t;

  localparam int COL_W_MIN = 8;
  localparam int COL_W_MAX = 10;
  localparam int A10_BIT   = 10;

  // Page code to column width; the reserved code falls into the largest page.
  function automatic int colWidth(input logic [1:0] code);
    case (code)
      2'b00:   return COL_W_MIN;
      2'b01:   return COL_W_MIN + 1;
      default: return COL_W_MAX;
    endcase
  endfunction

endpackage

// File: rtl/sdram_map_ctrl.sv
module sdram_map_ctrl
  import sdram_map_pkg::*;
(
  input  logic [1:0] phase,
  input  logic       isWrite,
  input  logic       acc64,
  input  logic       bus64,
  input  logic       addrLsb,
  output strobe_t    strb
);

  phase_e ph;
  logic   narrowWr;

  assign ph       = phase_e'(phase);
  assign narrowWr = isWrite & bus64 & ~acc64;

  always_comb begin
    strb.loadRow = (ph == PH_ROW);
    strb.loadCol = (ph == PH_COL);
    strb.loadAll = (ph == PH_ALL);
    strb.maskHi  = narrowWr & ~addrLsb;
    strb.maskLo  = narrowWr &  addrLsb;
    strb.wide    = bus64;
  end

endmodule

// File: rtl/sdram_map_dp.sv
module sdram_map_dp
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int BANK_W  = 2,
  parameter int ROW_W32 = 14,
  parameter int ROW_W64 = 13,
  parameter int BUS_W   = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        pageCode,
  output logic [BUS_W-1:0]  sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic              sdA10,
  output logic              hdqm,
  output logic              ldqm
);

  localparam int DEV_W = ROW_W32;

  int                shiftAmt;
  int                colW;
  int                rowW;
  logic [ADDR_W-1:0] colField;
  logic [ADDR_W-1:0] rowField;
  logic [BANK_W-1:0] bankField;
  logic [DEV_W-1:0]  devSel;
  logic [BUS_W-1:0]  busVal;

  // Field split: column lowest, then row, then bank.
  always_comb begin
    shiftAmt  = strb.wide ? 1 : 0;
    colW      = colWidth(pageCode);
    rowW      = strb.wide ? ROW_W64 : ROW_W32;
    colField  = (reqAddr >> shiftAmt) & ((ADDR_W'(1) << colW) - ADDR_W'(1));
    rowField  = (reqAddr >> (shiftAmt + colW)) & ((ADDR_W'(1) << rowW) - ADDR_W'(1));
    bankField = BANK_W'(reqAddr >> (shiftAmt + colW + rowW));
    devSel    = strb.loadRow ? DEV_W'(rowField) : DEV_W'(colField);
  end

  // Bus placement: bit 10 leaves the shared bus for the dedicated line.
  always_comb begin
    busVal = '0;
    for (int k = 0; k < DEV_W; k++) begin
      if (k != A10_BIT) begin
        if (strb.wide) busVal[k+1] = devSel[k];
        else           busVal[k]   = devSel[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdAddr <= '0;
      sdBank <= '0;
      sdA10  <= 1'b0;
      hdqm   <= 1'b0;
      ldqm   <= 1'b0;
    end else if (strb.loadAll) begin
      sdAddr <= '0;
      sdBank <= '0;
      sdA10  <= 1'b1;
      hdqm   <= 1'b0;
      ldqm   <= 1'b0;
    end else if (strb.loadRow) begin
      sdAddr <= busVal;
      sdBank <= bankField;
      sdA10  <= devSel[A10_BIT];
      hdqm   <= 1'b0;
      ldqm   <= 1'b0;
    end else if (strb.loadCol) begin
      sdAddr <= busVal;
      sdBank <= bankField;
      sdA10  <= 1'b0;
      hdqm   <= strb.maskHi;
      ldqm   <= strb.maskLo;
    end
  end

endmodule

// File: rtl/sdram_addr_mask_gen.sv
module sdram_addr_mask_gen
  import sdram_map_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W32 = 14,
  parameter int ROW_W64 = ROW_W32 - 1,
  parameter int ADDR_W  = COL_W_MAX + ROW_W32 + BANK_W,
  parameter int BUS_W   = ROW_W32 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        phase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              isWrite,
  input  logic              acc64,
  input  logic              bus64,
  input  logic [1:0]        pageCode,
  output logic [BUS_W-1:0]  sdAddr,
  output logic [BANK_W-1:0] sdBank,
  output logic              sdA10,
  output logic              hdqm,
  output logic              ldqm
);

  strobe_t strb;

  sdram_map_ctrl u_ctrl (
    .phase   (phase),
    .isWrite (isWrite),
    .acc64   (acc64),
    .bus64   (bus64),
    .addrLsb (reqAddr[0]),
    .strb    (strb)
  );

  sdram_map_dp #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .ROW_W32 (ROW_W32),
    .ROW_W64 (ROW_W64),
    .BUS_W   (BUS_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .pageCode (pageCode),
    .sdAddr   (sdAddr),
    .sdBank   (sdBank),
    .sdA10    (sdA10),
    .hdqm     (hdqm),
    .ldqm     (ldqm)
  );

endmodule

// File: rtl/sdram_addr_mask_gen_chk.sv
module sdram_addr_mask_gen_chk #(
  parameter int BUS_W  = 15,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        phase,
  input logic              isWrite,
  input logic              bus64,
  input logic [BUS_W-1:0]  sdAddr,
  input logic [BANK_W-1:0] sdBank,
  input logic              sdA10,
  input logic              hdqm,
  input logic              ldqm
);

  a_r6_all_banks: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b11) |=> (sdA10 && sdAddr == '0 && sdBank == '0 && !hdqm && !ldqm));

  a_r5_col_a10_low: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b10) |=> !sdA10);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b00) |=> ($stable(sdAddr) && $stable(sdBank) && $stable(sdA10)
                          && $stable(hdqm) && $stable(ldqm)));

  a_r9_read_nomask: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b10 && !isWrite) |=> (!hdqm && !ldqm));

  a_r9_row_nomask: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'b01) |=> (!hdqm && !ldqm));

  a_r8_lanes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hdqm && ldqm));

  a_r4_slot_clear: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'b00) |=> ($past(bus64) ? !sdAddr[11] : !sdAddr[10]));

  a_r4_wide_lsb_clear: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'b00 && bus64) |=> !sdAddr[0]);

endmodule

bind sdram_addr_mask_gen sdram_addr_mask_gen_chk #(.BUS_W(BUS_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sdram_addr_mask_gen_bench.sv
module sdram_addr_mask_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26;
  localparam int BUS_W  = 15;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  ph;
    logic        b64;
    logic [1:0]  pg;
    logic        wr;
    logic        a64;
    logic [1:0]  bank;
    logic [13:0] row;
    logic [9:0]  col;
    logic        lsb;
    logic [14:0] expBus;
    logic [1:0]  expBank;
    logic        expA10;
    logic        expH;
    logic        expL;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    // R3: 32-bit row, 256 page
    '{4'd3, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 14'h0005, 10'h000, 1'b0, 15'h0005, 2'd2, 1'b0, 1'b0, 1'b0},
    // R2: 32-bit column read
    '{4'd2, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 14'h0005, 10'h003, 1'b0, 15'h0003, 2'd2, 1'b0, 1'b0, 1'b0},
    // R4: row bit 10 goes to the A10 line, 32-bit slot cleared
    '{4'd4, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 14'h0400, 10'h000, 1'b0, 15'h0000, 2'd1, 1'b1, 1'b0, 1'b0},
    // R3: high row bits in 32-bit mode, 1024 page
    '{4'd3, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd3, 14'h3801, 10'h000, 1'b0, 15'h3801, 2'd3, 1'b0, 1'b0, 1'b0},
    // R9: 32-bit mode odd narrow write, no mask
    '{4'd9, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 2'd3, 14'h0000, 10'h3FF, 1'b0, 15'h03FF, 2'd3, 1'b0, 1'b0, 1'b0},
    // R4: 64-bit row with bit 10 set, bus shifted
    '{4'd4, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 14'h1555, 10'h000, 1'b0, 15'h22AA, 2'd2, 1'b1, 1'b0, 1'b0},
    // R8: 64-bit even narrow write
    '{4'd8, 2'd2, 1'b1, 2'd1, 1'b1, 1'b0, 2'd2, 14'h0000, 10'h1AB, 1'b0, 15'h0356, 2'd2, 1'b0, 1'b1, 1'b0},
    // R8: 64-bit odd narrow write
    '{4'd8, 2'd2, 1'b1, 2'd1, 1'b1, 1'b0, 2'd2, 14'h0000, 10'h1AB, 1'b1, 15'h0356, 2'd2, 1'b0, 1'b0, 1'b1},
    // R8: 64-bit wide write
    '{4'd8, 2'd2, 1'b1, 2'd0, 1'b1, 1'b1, 2'd1, 14'h0000, 10'h0FF, 1'b1, 15'h01FE, 2'd1, 1'b0, 1'b0, 1'b0},
    // R9: 64-bit narrow read
    '{4'd9, 2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 14'h0000, 10'h155, 1'b1, 15'h02AA, 2'd0, 1'b0, 1'b0, 1'b0},
    // R6: all-banks phase
    '{4'd6, 2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 2'd3, 14'h1FFF, 10'h1FF, 1'b1, 15'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    // R11: reserved page code, row
    '{4'd11, 2'd1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd1, 14'h0ABC, 10'h000, 1'b0, 15'h1578, 2'd1, 1'b0, 1'b0, 1'b0},
    // R11: reserved page code, column (R5: row bits not on bus)
    '{4'd11, 2'd2, 1'b1, 2'd3, 1'b0, 1'b0, 2'd1, 14'h0ABC, 10'h3FF, 1'b0, 15'h07FE, 2'd1, 1'b0, 1'b0, 1'b0},
    // R4: 64-bit row bit 10 only
    '{4'd4, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 14'h0400, 10'h000, 1'b0, 15'h0000, 2'd0, 1'b1, 1'b0, 1'b0},
    // R5: column after row drops A10
    '{4'd5, 2'd2, 1'b1, 2'd2, 1'b1, 1'b0, 2'd0, 14'h0400, 10'h002, 1'b0, 15'h0004, 2'd0, 1'b0, 1'b1, 1'b0},
    // R9: row phase clears masks
    '{4'd9, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 14'h0001, 10'h000, 1'b0, 15'h0002, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        phase = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              isWrite = 1'b0;
  logic              acc64 = 1'b0;
  logic              bus64 = 1'b0;
  logic [1:0]        pageCode = 2'b00;
  logic [BUS_W-1:0]  sdAddr;
  logic [1:0]        sdBank;
  logic              sdA10;
  logic              hdqm;
  logic              ldqm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_addr_mask_gen u_sdram_addr_mask_gen (
    .clk(clk), .rstN(rstN), .phase(phase), .reqAddr(reqAddr),
    .isWrite(isWrite), .acc64(acc64), .bus64(bus64), .pageCode(pageCode),
    .sdAddr(sdAddr), .sdBank(sdBank), .sdA10(sdA10), .hdqm(hdqm), .ldqm(ldqm)
  );

  // Address built from fields as the requirements R2/R3 place them.
  function automatic logic [ADDR_W-1:0] compose(input logic b64, input logic [1:0] pg,
      input logic [1:0] bank, input logic [13:0] row, input logic [9:0] col, input logic lsb);
    int c, r, s;
    c = (pg == 2'd0) ? 8 : (pg == 2'd1) ? 9 : 10;
    r = b64 ? 13 : 14;
    s = b64 ? 1 : 0;
    return (ADDR_W'(bank) << (s + c + r)) | (ADDR_W'(row) << (s + c))
         | (ADDR_W'(col) << s) | ADDR_W'(b64 & lsb);
  endfunction

  task automatic expectAll(input string tag, input logic [14:0] eBus, input logic [1:0] eBank,
                           input logic eA10, input logic eH, input logic eL);
    checks++;
    if (sdAddr !== eBus || sdBank !== eBank || sdA10 !== eA10 || hdqm !== eH || ldqm !== eL) begin
      fails++;
      $display("FAIL %s: bus=%h bank=%0d a10=%b h=%b l=%b expected bus=%h bank=%0d a10=%b h=%b l=%b",
               tag, sdAddr, sdBank, sdA10, hdqm, ldqm, eBus, eBank, eA10, eH, eL);
    end
  endtask

  task automatic drive(input vec_t v);
    phase    = v.ph;
    bus64    = v.b64;
    pageCode = v.pg;
    isWrite  = v.wr;
    acc64    = v.a64;
    reqAddr  = compose(v.b64, v.pg, v.bank, v.row, v.col, v.lsb);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectAll("R1 in reset", '0, '0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectAll("R1 after release", '0, '0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      expectAll($sformatf("R%0d vec %0d", VECS[i].req, i),
                VECS[i].expBus, VECS[i].expBank, VECS[i].expA10, VECS[i].expH, VECS[i].expL);
    end

    // R7: hold phase with every other input changed
    phase    = 2'b00;
    bus64    = 1'b0;
    pageCode = 2'd0;
    isWrite  = 1'b1;
    acc64    = 1'b0;
    reqAddr  = '1;
    repeat (2) @(negedge clk);
    expectAll("R7 hold", 15'h0002, 2'd0, 1'b0, 1'b0, 1'b0);

    // R10: new row presented, output unchanged before the edge, updated after it
    phase    = 2'b01;
    bus64    = 1'b0;
    pageCode = 2'd0;
    reqAddr  = compose(1'b0, 2'd0, 2'd1, 14'h0003, 10'h000, 1'b0);
    #1;
    expectAll("R10 before edge", 15'h0002, 2'd0, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    expectAll("R10 after edge", 15'h0003, 2'd1, 1'b0, 1'b0, 1'b0);

    // R1: reset mid-run returns outputs to zero
    phase = 2'b11;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    expectAll("R1 mid-run reset", '0, '0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule